// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register Block

This block gathers a parameterized set of interrupt request lines into a pending-status register and masks them with a per-line enable register. It drives one interrupt output towards a processor. Software reaches every register through a plain single-cycle register port with a write strobe, a word address and write data. Read data is a combinational function of the address and the current register state, and a read has no side effects.

The enable mask can be loaded whole, or changed bit by bit through separate set-bits and clear-bits addresses. Pending bits are cleared by writing ones to an acknowledge address. A read-only vector address reports the index of the most urgent line that is both pending and enabled. Line 0 is the most urgent.

A two-bit control register holds a master gate for the interrupt output and a hardware-mode bit. After reset the block is in a test mode: software sets pending bits directly and the physical lines are ignored. Setting the hardware-mode bit switches pending capture to rising edges on the physical lines. Once set, that bit stays set until reset.

Top module: `prio_intc`

## Requirements
- R1: After reset the status, enable and control registers read zero, the vector address reads all ones and `irq_o` is low.
- R2: Address 2 holds the enable mask and reads it back. A write to address 4 sets each enable bit whose write-data bit is 1. A write to address 5 clears each enable bit whose write-data bit is 1. A 0 written to address 4 or 5 leaves that enable bit unchanged. Addresses 4 and 5 read as zero.
- R3: Address 6 reads the index of the lowest-numbered line that is both pending and enabled, zero-extended. It reads all ones when no such line exists.
- R4: Address 7 is the control register: bit 0 is master enable and bit 1 is hardware mode. Write-data bits above bit 1 are ignored, and a read returns the two bits with all upper bits zero.
- R5: `irq_o` is registered. One clock after the registers change, it is high exactly when master enable is 1 and at least one line is pending and enabled.
- R6: While hardware mode is 0, a write to address 0 sets each status bit whose write-data bit is 1, and the `irq_in` lines cannot set any status bit.
- R7: Writing 1 to control bit 1 sets hardware mode, and later writes cannot clear it before reset. While hardware mode is 1, writes to address 0 change no status bit.
- R8: While hardware mode is 1, a line that is high in this cycle and was low in the previous cycle sets its status bit. A line held high sets its bit only once.
- R9: A write to address 3 clears each status bit whose write-data bit is 1. If a new rising edge on a line arrives in the same cycle, that line's status bit ends up set.
- R10: Address 1 reads the bitwise AND of status and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq_in | input | NUM_IN | Interrupt request lines, already synchronous to `clk` |
| irq_o | output | 1 | Gated interrupt request to the processor |

## Verification
The assertions take for granted that `bus_wr`, `bus_addr` and `irq_in` carry known values in every clock after reset and are already synchronous to `clk`, so a rising edge on a line is a one-cycle event. They also assume `NUM_IN` is no larger than `DATA_W`. The stimulus changes every input only on the falling clock edge. It reads back results only after the rising edge that commits them, so each line and each write is seen in exactly one capture cycle. Edge and acknowledge collisions are therefore produced by changing the line and the write strobe in the same half period.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int ADDR_W = 3;

  // Word addresses of the register port.
  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_PEND   = 3'd1,
    A_ENABLE = 3'd2,
    A_ACK    = 3'd3,
    A_SETEN  = 3'd4,
    A_CLREN  = 3'd5,
    A_VECTOR = 3'd6,
    A_CTRL   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic hw_mode;    // bit 1
    logic master_en;  // bit 0
  } ctrl_t;

endpackage

// File: rtl/prio_intc_edge.sv
module prio_intc_edge #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] lvl_i,
  output logic [NUM_IN-1:0] rise_o
);

  logic [NUM_IN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/prio_intc_encoder.sv
module prio_intc_encoder #(
  parameter int NUM_IN = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_IN-1:0] pend_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_IN-1:0] grant_o
);

  // below[i] is high when any line with a smaller index is pending.
  logic [NUM_IN-1:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < NUM_IN; i++) begin : g_chain
    assign below[i] = below[i-1] | pend_i[i-1];
  end

  assign grant_o = pend_i & ~below;
  assign valid_o = |pend_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/prio_intc_regfile.sv
module prio_intc_regfile
  import prio_intc_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  reg_addr_e         addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_IN-1:0] rise_i,
  output logic [NUM_IN-1:0] status_o,
  output logic [NUM_IN-1:0] enable_o,
  output ctrl_t             ctrl_o
);

  logic [NUM_IN-1:0] status_q, status_d;
  logic [NUM_IN-1:0] enable_q, enable_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [NUM_IN-1:0] wbits;
  logic [NUM_IN-1:0] evt;
  logic              unused_wdata;

  assign wbits        = wdata_i[NUM_IN-1:0];
  assign unused_wdata = ^wdata_i;
  assign evt          = ctrl_q.hw_mode ? rise_i : '0;

  // Acknowledge first, then new events, so an event in the same cycle wins.
  always_comb begin
    status_d = status_q;
    if (wr_i && addr_i == A_ACK) status_d = status_d & ~wbits;
    if (wr_i && addr_i == A_STATUS && !ctrl_q.hw_mode) status_d = status_d | wbits;
    status_d = status_d | evt;
  end

  always_comb begin
    enable_d = enable_q;
    if (wr_i) begin
      unique case (addr_i)
        A_ENABLE: enable_d = wbits;
        A_SETEN:  enable_d = enable_q | wbits;
        A_CLREN:  enable_d = enable_q & ~wbits;
        default:  enable_d = enable_q;
      endcase
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i && addr_i == A_CTRL) begin
      ctrl_d.master_en = wdata_i[0];
      if (wdata_i[1]) ctrl_d.hw_mode = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      ctrl_q   <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      ctrl_q   <= ctrl_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign ctrl_o   = ctrl_q;

  AST_HW_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.hw_mode |=> ctrl_q.hw_mode); // R7

  AST_SW_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.hw_mode && wr_i && addr_i == A_STATUS)
      |=> ((status_q & ~$past(status_q) & ~$past(rise_i)) == '0)); // R7

  AST_TEST_MODE_NO_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.hw_mode && !(wr_i && addr_i == A_STATUS))
      |=> ((status_q & ~$past(status_q)) == '0)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_ACK)
      |=> ((status_q & $past(wbits) & ~$past(evt)) == '0)); // R9

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt))); // R8

  AST_SETEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_SETEN)
      |=> ((enable_q & $past(wbits)) == $past(wbits))); // R2

  AST_CLREN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_CLREN) |=> ((enable_q & $past(wbits)) == '0)); // R2

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int DATA_W  = 32,
  parameter bit HAS_VEC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              irq_o
);

  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  reg_addr_e         addr;
  logic [NUM_IN-1:0] rise;
  logic [NUM_IN-1:0] status;
  logic [NUM_IN-1:0] enable;
  logic [NUM_IN-1:0] pend;
  ctrl_t             ctrl;
  logic              vec_valid;
  logic [IDX_W-1:0]  vec_idx;
  logic [NUM_IN-1:0] vec_grant;
  logic [DATA_W-1:0] vec_word;
  logic              irq_q;

  assign addr = reg_addr_e'(bus_addr);

  prio_intc_edge #(.NUM_IN(NUM_IN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (irq_in),
    .rise_o (rise)
  );

  prio_intc_regfile #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr),
    .addr_i   (addr),
    .wdata_i  (bus_wdata),
    .rise_i   (rise),
    .status_o (status),
    .enable_o (enable),
    .ctrl_o   (ctrl)
  );

  assign pend = status & enable;

  if (HAS_VEC) begin : g_vec
    prio_intc_encoder #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_enc (
      .pend_i  (pend),
      .valid_o (vec_valid),
      .idx_o   (vec_idx),
      .grant_o (vec_grant)
    );
    assign vec_word = vec_valid ? DATA_W'(vec_idx) : '1;
  end else begin : g_novec
    assign vec_valid = 1'b0;
    assign vec_idx   = '0;
    assign vec_grant = '0;
    assign vec_word  = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= ctrl.master_en & (|pend);
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (addr)
      A_STATUS: bus_rdata = DATA_W'(status);
      A_PEND:   bus_rdata = DATA_W'(pend);
      A_ENABLE: bus_rdata = DATA_W'(enable);
      A_VECTOR: bus_rdata = vec_word;
      A_CTRL:   bus_rdata = DATA_W'(ctrl);
      default:  bus_rdata = '0;
    endcase
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.master_en |=> !irq_o); // R5

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.master_en && (|pend)) |=> irq_o); // R5

  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> pend[vec_idx]); // R3

  AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((pend & ((NUM_IN'(1) << vec_idx) - NUM_IN'(1))) == '0)); // R3

  AST_VEC_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_grant)); // R3

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;

  localparam int NUM_IN = 8;
  localparam int DATA_W = 32;
  localparam int HALF   = 10;   // 50 MHz clock

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'd1,  3'd7, 32'h0, 32'h0},          // R1 control reset
    '{1'b0, 4'd1,  3'd6, 32'h0, 32'hFFFF_FFFF},  // R1 vector reset
    '{1'b0, 4'd1,  3'd0, 32'h0, 32'h0},          // R1 status reset
    '{1'b1, 4'd2,  3'd2, 32'hF0, 32'h0},         // R2 load enable
    '{1'b0, 4'd2,  3'd2, 32'h0, 32'hF0},
    '{1'b1, 4'd2,  3'd4, 32'h05, 32'h0},         // R2 set bits
    '{1'b0, 4'd2,  3'd2, 32'h0, 32'hF5},
    '{1'b1, 4'd2,  3'd5, 32'h30, 32'h0},         // R2 clear bits
    '{1'b0, 4'd2,  3'd2, 32'h0, 32'hC5},
    '{1'b0, 4'd2,  3'd4, 32'h0, 32'h0},          // R2 write-only reads zero
    '{1'b0, 4'd2,  3'd5, 32'h0, 32'h0},
    '{1'b1, 4'd6,  3'd0, 32'h28, 32'h0},         // R6 software raise
    '{1'b0, 4'd6,  3'd0, 32'h0, 32'h28},
    '{1'b0, 4'd10, 3'd1, 32'h0, 32'h0},          // R10 none enabled
    '{1'b0, 4'd3,  3'd6, 32'h0, 32'hFFFF_FFFF},  // R3 none -> all ones
    '{1'b1, 4'd6,  3'd0, 32'h82, 32'h0},         // R6 bits OR in
    '{1'b0, 4'd10, 3'd1, 32'h0, 32'h80},
    '{1'b0, 4'd3,  3'd6, 32'h0, 32'h7},          // R3 only line 7
    '{1'b1, 4'd2,  3'd4, 32'h08, 32'h0},
    '{1'b0, 4'd3,  3'd6, 32'h0, 32'h3},          // R3 line 3 beats 7
    '{1'b1, 4'd9,  3'd3, 32'h08, 32'h0},         // R9 acknowledge
    '{1'b0, 4'd9,  3'd0, 32'h0, 32'hA2},
    '{1'b0, 4'd3,  3'd6, 32'h0, 32'h7},
    '{1'b1, 4'd4,  3'd7, 32'hFFFF_FFFD, 32'h0},  // R4 upper bits ignored
    '{1'b0, 4'd4,  3'd7, 32'h0, 32'h1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [2:0]        bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_IN-1:0] irq_in = '0;
  logic              irq_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #HALF clk = ~clk;

  prio_intc #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_o     (irq_o)
  );

  // Called at a falling edge; returns at the falling edge after the commit.
  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic check_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #2;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic check_irq(input logic exp, input string tag);
    n_chk++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(2 * HALF * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_irq(1'b0, "R1 irq after reset");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) begin
        do_write(TBL[i].addr, TBL[i].data);
      end else begin
        check_read(TBL[i].addr, TBL[i].exp, $sformatf("R%0d vector %0d", TBL[i].req, i));
      end
    end

    // State now: status A2, enable CD, master enable on, test mode.
    @(negedge clk);
    check_irq(1'b1, "R5 raised when gated on");
    do_write(3'd7, 32'h0);
    check_irq(1'b1, "R5 one clock latency");
    @(negedge clk);
    check_irq(1'b0, "R5 masked by master enable");
    do_write(3'd7, 32'h1);

    irq_in = 8'h01;
    repeat (2) @(negedge clk);
    check_read(3'd0, 32'hA2, "R6 lines ignored in test mode");

    do_write(3'd7, 32'h3);
    check_read(3'd7, 32'h3, "R7 hardware mode set");
    check_read(3'd0, 32'hA2, "R8 held level is not an edge");
    do_write(3'd0, 32'h01);
    check_read(3'd0, 32'hA2, "R7 status write ignored");
    do_write(3'd7, 32'h0);
    check_read(3'd7, 32'h2, "R7 mode bit locked");
    do_write(3'd7, 32'h1);
    check_read(3'd7, 32'h3, "R4 master enable back on");

    @(negedge clk);
    irq_in = 8'h00;
    @(negedge clk);
    irq_in = 8'h04;
    @(negedge clk);
    check_read(3'd0, 32'hA6, "R8 rising edge captured");
    check_read(3'd6, 32'h2, "R3 captured line wins");

    irq_in = 8'h14;
    do_write(3'd3, 32'h14);
    check_read(3'd0, 32'hB2, "R9 new edge beats acknowledge");
    repeat (2) @(negedge clk);
    check_read(3'd0, 32'hB2, "R8 no repeat capture while high");

    do_write(3'd3, 32'hFF);
    check_read(3'd0, 32'h0, "R9 acknowledge all");
    check_read(3'd6, 32'hFFFF_FFFF, "R3 empty again");
    @(negedge clk);
    check_irq(1'b0, "R5 drops after acknowledge");

    finish_run();
  end

endmodule